// File: doc/BRIEF.md
# CAN FD Transmitter Delay Compensation Unit

This block sits beside the data-phase bit logic of a CAN FD controller. While the data phase is active it times the loop delay of the transceiver, counting controller clocks from a falling edge on the transmit line to the falling edge that comes back on the receive line. From that measurement it places a secondary sample point, which it hands to the bit-error checker.

A single 32-bit control/status word is written and read through a plain write strobe and a read bus. Software picks one of three behaviours with the mode field. In automatic mode the secondary point is the measured delay plus the configured sample point plus a signed offset. In manual mode the measurement is not used: the point is the sample point plus an unsigned offset. When compensation is off, the checker is told to use the normal sample point. A minimum-delay field rejects implausibly short measurements as glitches.

Top module: `tdc_unit`

## Requirements
- R1: After a synchronous reset the whole control/status word reads 0, which selects automatic mode with zero offset and zero minimum, and `ssp_valid` is low.
- R2: Register layout: bits [5:0] hold the measured delay and are read-only, bits [13:8] hold the minimum delay, bits [21:16] hold the offset and bits [31:30] hold the mode. Writes to the delay field and to all other bits are ignored, and those other bits read 0.
- R3: While `data_phase` is high, a TX falling edge followed D clocks later by an RX falling edge (D from 1 to 63) stores D in bits [5:0].
- R4: The delay counter saturates: a loop delay above 63 clocks is stored as 63.
- R5: When `data_phase` is low, edges on TX and RX start no measurement, and the stored delay is unchanged.
- R6: A measured delay below the minimum field is rejected, and the earlier stored value is kept. A delay equal to or above the minimum is stored.
- R7: Mode code 0 (automatic): `ssp_pos` = stored delay + `sample_point` + offset, with the offset read as a 6-bit two's complement value. A negative result is clamped to 0. `ssp_valid` is high when the stored delay is nonzero.
- R8: In automatic mode an offset of 0 gives `ssp_pos` = stored delay + `sample_point`.
- R9: Mode code 1 (manual): `ssp_pos` = `sample_point` + offset, with the offset read as unsigned 0..63. The stored delay is not used, and `ssp_valid` is high.
- R10: Mode codes 3 and 2 (off): `ssp_valid` is low and `ssp_pos` equals `sample_point`.
- R11: In automatic mode, while the stored delay is 0 (no valid measurement), `ssp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control/status word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control/status word |
| tx | input | 1 | Transmit line as driven by the controller |
| rx | input | 1 | Receive line from the transceiver |
| data_phase | input | 1 | High while the data phase is in progress |
| sample_point | input | SP_W | Configured sample point position in clocks |
| ssp_pos | output | SP_W+1 | Secondary sample point position in clocks |
| ssp_valid | output | 1 | Secondary sample point is in use |

## Verification
On every cycle the assertions check several rules. The stored delay stays constant outside the data phase and across rejected glitches. Off modes never raise `ssp_valid`, manual mode always raises it, and automatic mode without a measurement keeps it low. Manual placement never lands before the sample point. Only the bench scenarios can show the following: the exact stored delay for each loop delay including saturation, the arithmetic of both offset interpretations over full offset sweeps and several sample points, the clamp at zero, and the masking of read-only and unused register bits.

// File: rtl/tdc_pkg.sv
`timescale 1ns/1ps
package tdc_pkg;
  localparam int TDC_FW      = 6;
  localparam int MEAS_LSB    = 0;
  localparam int MIN_LSB     = 8;
  localparam int OFS_LSB     = 16;
  localparam int MODE_LSB    = 30;
  localparam int REG_W       = 32;

  typedef enum logic [1:0] {
    TDC_AUTO   = 2'd0,
    TDC_MANUAL = 2'd1,
    TDC_OFF_B  = 2'd2,
    TDC_OFF    = 2'd3
  } tdc_mode_e;
endpackage

// File: rtl/tdc_ctrl_reg.sv
`timescale 1ns/1ps
module tdc_ctrl_reg
  import tdc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_W-1:0]      wr_data,
  output logic [TDC_FW-1:0]     min_o,
  output logic [TDC_FW-1:0]     ofs_o,
  output tdc_mode_e             mode_o
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[MIN_LSB-1:0], wr_data[OFS_LSB-1:MIN_LSB+TDC_FW],
                            wr_data[MODE_LSB-1:OFS_LSB+TDC_FW]};

  always_ff @(posedge clk) begin
    if (rst) begin
      min_o  <= '0;
      ofs_o  <= '0;
      mode_o <= TDC_AUTO;
    end else if (wr_en) begin
      min_o  <= wr_data[MIN_LSB +: TDC_FW];
      ofs_o  <= wr_data[OFS_LSB +: TDC_FW];
      mode_o <= tdc_mode_e'(wr_data[MODE_LSB +: 2]);
    end
  end
endmodule

// File: rtl/tdc_delay_meas.sv
`timescale 1ns/1ps
module tdc_delay_meas #(
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          data_phase,
  input  logic          tx,
  input  logic          rx,
  input  logic [FW-1:0] min_i,
  output logic [FW-1:0] meas_o
);
  localparam logic [FW-1:0] CNT_MAX = {FW{1'b1}};
  localparam logic [FW-1:0] CNT_ONE = FW'(1);

  logic          tx_q, rx_q, running;
  logic [FW-1:0] cnt;
  logic          tx_fall, rx_fall;

  assign tx_fall = tx_q & ~tx;
  assign rx_fall = rx_q & ~rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q    <= 1'b1;
      rx_q    <= 1'b1;
      running <= 1'b0;
      cnt     <= '0;
      meas_o  <= '0;
    end else begin
      tx_q <= tx;
      rx_q <= rx;
      if (!data_phase) begin
        running <= 1'b0;
      end else if (!running) begin
        if (tx_fall) begin
          running <= 1'b1;
          cnt     <= CNT_ONE;
        end
      end else if (rx_fall) begin
        running <= 1'b0;
        if (cnt >= min_i) meas_o <= cnt;
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + CNT_ONE;
      end
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !data_phase |=> $stable(meas_o)); // R5

  AST_GLITCH_KEEP: assert property (@(posedge clk) disable iff (rst)
    (data_phase && running && rx_fall && (cnt < min_i)) |=> $stable(meas_o)); // R6
endmodule

// File: rtl/tdc_ssp_calc.sv
`timescale 1ns/1ps
module tdc_ssp_calc
  import tdc_pkg::*;
#(
  parameter int FW    = 6,
  parameter int SP_W  = 8,
  parameter int SSP_W = SP_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  tdc_mode_e        mode_i,
  input  logic [FW-1:0]    ofs_i,
  input  logic [FW-1:0]    meas_i,
  input  logic [SP_W-1:0]  sp_i,
  output logic [SSP_W-1:0] ssp_o,
  output logic             valid_o
);
  localparam int CW = SSP_W + 2;
  localparam logic signed [CW-1:0] SSP_MAX = CW'((1 << SSP_W) - 1);

  logic signed [CW-1:0] ofs_s, meas_s, sp_s, sum;
  logic [SSP_W-1:0]     clamped;
  logic                 is_auto, is_man;

  assign is_auto = (mode_i == TDC_AUTO);
  assign is_man  = (mode_i == TDC_MANUAL);

  always_comb begin
    sp_s   = $signed({{(CW-SP_W){1'b0}}, sp_i});
    meas_s = is_auto ? $signed({{(CW-FW){1'b0}}, meas_i}) : '0;
    if (is_auto) ofs_s = $signed({{(CW-FW){ofs_i[FW-1]}}, ofs_i});
    else         ofs_s = $signed({{(CW-FW){1'b0}}, ofs_i});
    sum = sp_s + meas_s + ofs_s;
    if (sum < 0)             clamped = '0;
    else if (sum > SSP_MAX)  clamped = SSP_MAX[SSP_W-1:0];
    else                     clamped = sum[SSP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ssp_o   <= '0;
      valid_o <= 1'b0;
    end else if (is_auto) begin
      ssp_o   <= clamped;
      valid_o <= (meas_i != '0);
    end else if (is_man) begin
      ssp_o   <= clamped;
      valid_o <= 1'b1;
    end else begin
      ssp_o   <= {{(SSP_W-SP_W){1'b0}}, sp_i};
      valid_o <= 1'b0;
    end
  end

  AST_OFF_INVALID: assert property (@(posedge clk) disable iff (rst)
    mode_i[1] |=> !valid_o); // R10

  AST_MAN_VALID: assert property (@(posedge clk) disable iff (rst)
    (mode_i == TDC_MANUAL) |=> valid_o); // R9

  AST_MAN_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (mode_i == TDC_MANUAL) |=> (ssp_o >= {{(SSP_W-SP_W){1'b0}}, $past(sp_i)})); // R9

  AST_AUTO_NOMEAS: assert property (@(posedge clk) disable iff (rst)
    ((mode_i == TDC_AUTO) && (meas_i == '0)) |=> !valid_o); // R11
endmodule

// File: rtl/tdc_unit.sv
`timescale 1ns/1ps
module tdc_unit
  import tdc_pkg::*;
#(
  parameter int SP_W  = 8,
  parameter int SSP_W = SP_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic             tx,
  input  logic             rx,
  input  logic             data_phase,
  input  logic [SP_W-1:0]  sample_point,
  output logic [SSP_W-1:0] ssp_pos,
  output logic             ssp_valid
);
  logic [TDC_FW-1:0] min_q, ofs_q, meas_q;
  tdc_mode_e         mode_q;

  tdc_ctrl_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .min_o   (min_q),
    .ofs_o   (ofs_q),
    .mode_o  (mode_q)
  );

  tdc_delay_meas #(.FW(TDC_FW)) u_meas (
    .clk        (clk),
    .rst        (rst),
    .data_phase (data_phase),
    .tx         (tx),
    .rx         (rx),
    .min_i      (min_q),
    .meas_o     (meas_q)
  );

  tdc_ssp_calc #(.FW(TDC_FW), .SP_W(SP_W), .SSP_W(SSP_W)) u_calc (
    .clk     (clk),
    .rst     (rst),
    .mode_i  (mode_q),
    .ofs_i   (ofs_q),
    .meas_i  (meas_q),
    .sp_i    (sample_point),
    .ssp_o   (ssp_pos),
    .valid_o (ssp_valid)
  );

  always_comb begin
    rd_data = '0;
    rd_data[MEAS_LSB +: TDC_FW] = meas_q;
    rd_data[MIN_LSB  +: TDC_FW] = min_q;
    rd_data[OFS_LSB  +: TDC_FW] = ofs_q;
    rd_data[MODE_LSB +: 2]      = mode_q;
  end
endmodule

// File: tb/tdc_unit_test.sv
`timescale 1ns/1ps
module tdc_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        tx = 1'b1, rx = 1'b1, data_phase = 1'b0;
  logic [7:0]  sample_point = '0;
  logic [8:0]  ssp_pos;
  logic        ssp_valid;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  tdc_unit uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .tx(tx), .rx(rx), .data_phase(data_phase), .sample_point(sample_point),
    .ssp_pos(ssp_pos), .ssp_valid(ssp_valid)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic loop(input int d, input logic ph);
    @(negedge clk); data_phase = ph; tx = 1'b0;
    repeat (d) @(negedge clk);
    rx = 1'b0;
    repeat (2) @(negedge clk);
    tx = 1'b1; rx = 1'b1;
    repeat (2) @(negedge clk);
    data_phase = 1'b1;
  endtask

  function automatic logic [31:0] cfg(input int mode, input int ofs, input int mn);
    return (32'(mode) << 30) | (32'(ofs & 63) << 16) | (32'(mn) << 8);
  endfunction

  initial begin
    int exp_d;
    int ssp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset word", rd_data, 0);
    @(negedge clk);
    chk("R1 reset valid", ssp_valid, 0);
    chk("R11 auto no meas valid", ssp_valid, 0);

    wr(32'hFFFF_FFFF);
    chk("R2 layout all ones", rd_data, 32'hC03F_3F00);
    sample_point = 8'd77; @(negedge clk);
    chk("R10 off3 valid", ssp_valid, 0);
    chk("R10 off3 pos", ssp_pos, 77);
    wr(32'h8000_0000);
    chk("R2 mode2 readback", rd_data, 32'h8000_0000);
    chk("R10 off2 valid", ssp_valid, 0);
    chk("R10 off2 pos", ssp_pos, 77);
    wr(32'h3FC0_C0FF);
    chk("R2 unused bits", rd_data, 0);

    wr(cfg(0, 0, 0));
    sample_point = 8'd20;
    data_phase = 1'b1;
    for (int d = 1; d <= 75; d++) begin
      if (d > 12 && d != 40 && d != 62 && d != 63 && d != 64 && d != 75) continue;
      loop(d, 1'b1);
      exp_d = (d > 63) ? 63 : d;
      chk(d > 63 ? "R4 saturate" : "R3 measure", rd_data[5:0], exp_d);
      chk("R8 auto zero offset", ssp_pos, exp_d + 20);
      chk("R7 auto valid", ssp_valid, 1);
    end

    loop(12, 1'b0);
    chk("R5 outside data phase", rd_data[5:0], 63);
    loop(9, 1'b1);
    chk("R3 measure 9", rd_data[5:0], 9);

    wr(cfg(0, 0, 5));
    loop(3, 1'b1);
    chk("R6 glitch rejected", rd_data[5:0], 9);
    loop(5, 1'b1);
    chk("R6 at minimum accepted", rd_data[5:0], 5);

    foreach (sample_point[i]) begin end
    for (int s = 0; s < 3; s++) begin
      sample_point = (s == 0) ? 8'd0 : (s == 1) ? 8'd17 : 8'd200;
      for (int o = 0; o < 64; o++) begin
        wr(cfg(0, o, 5));
        @(negedge clk);
        ssp = 5 + int'(sample_point) + ((o > 31) ? o - 64 : o);
        if (ssp < 0) ssp = 0;
        chk("R7 auto signed offset", ssp_pos, ssp);
        chk("R7 auto valid", ssp_valid, 1);
      end
    end

    for (int s = 0; s < 3; s++) begin
      sample_point = (s == 0) ? 8'd0 : (s == 1) ? 8'd90 : 8'd255;
      for (int o = 0; o < 64; o++) begin
        wr(cfg(1, o, 5));
        @(negedge clk);
        chk("R9 manual unsigned offset", ssp_pos, int'(sample_point) + o);
        chk("R9 manual valid", ssp_valid, 1);
      end
    end
    wr(cfg(1, 7, 0));
    sample_point = 8'd30;
    loop(20, 1'b1);
    chk("R9 manual still measures", rd_data[5:0], 20);
    chk("R9 manual ignores delay", ssp_pos, 37);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule